// File: doc/BRIEF.md
# Programmable Codeword Branch Metric Unit

This block produces hard-decision branch metrics for a convolutional decoder that can be retargeted to different codes at run time. It holds no fixed encoder model. A codeword table, written through a simple address/data configuration port, stores the expected output codeword of every butterfly. Software fills the table from whatever generator polynomials are in use. The same unit therefore serves constraint lengths 3 through 9 at rate 1/2 or rate 1/3.

For each received symbol (up to three hard bits with a valid strobe), every active butterfly compares the bits against its stored codeword. It also compares them against the bitwise complement of that codeword, which is the codeword of the butterfly's other branch. The two resulting Hamming distances are registered and presented one cycle later, each with a per-butterfly valid flag. The number of active butterflies follows the selected constraint length. The remaining butterflies are held at zero.

Top module: `programmable_bmu`

## Requirements
- R1: After synchronous reset, `out_valid`, every `lane_valid` bit and every metric are 0, and every table entry holds codeword 3'b000.
- R2: A cycle with `cfg_we` high stores `cfg_data` as the codeword of butterfly `cfg_addr`. Bit 0 is the first coded bit, bit 1 the second and bit 2 the third. Symbols presented in later cycles use the stored value, and rewriting an entry replaces it.
- R3: For active butterfly i, `bm_same` lane i equals the number of unmasked bit positions where `rx_bits` differs from the stored codeword.
- R4: For active butterfly i, `bm_flip` lane i equals the number of unmasked bit positions where `rx_bits` differs from the complement of the stored codeword. The two metrics of a lane therefore sum to n.
- R5: With `rate_third` = 1 all three bits count (n=3). With `rate_third` = 0, bit 2 of both the received bits and the codeword is ignored (n=2).
- R6: `out_valid` is high exactly in the cycle after a cycle with `rx_valid` high, and the metrics in that cycle belong to that symbol.
- R7: Only butterflies with index below 2^(K-2) are active. All others output zero metrics with `lane_valid` low.
- R8: In the cycle after a cycle with `rx_valid` low, every `lane_valid` bit and every metric is 0.
- R9: A `k_len` below 3 is treated as 3 and a `k_len` above 9 is treated as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Codeword table write enable |
| cfg_addr | input | MAX_K-2 | Butterfly index to write |
| cfg_data | input | 3 | Codeword to store |
| rx_valid | input | 1 | Received symbol strobe |
| rx_bits | input | 3 | Received hard bits, bit 0 first |
| k_len | input | 4 | Active constraint length |
| rate_third | input | 1 | 1 selects rate 1/3, 0 selects rate 1/2 |
| out_valid | output | 1 | Metrics valid for the previous symbol |
| lane_valid | output | 2^(MAX_K-2) | Per-butterfly active flag |
| bm_same | output | 2*2^(MAX_K-2) | Per-butterfly distance to the stored codeword, 2 bits per lane |
| bm_flip | output | 2*2^(MAX_K-2) | Per-butterfly distance to the complemented codeword, 2 bits per lane |

## Verification
The bench builds the block with the default MAX_K of 9, so the table has all 128 entries and every constraint length from 3 to 9 can be selected, including the full 128-lane case and the smallest 2-lane case. Out-of-range `k_len` values on both sides are reachable through the 4-bit port. A distinct codeword pattern across all entries lets a lane-mapping or masking error show up in at least one lane for every received pattern at both rates.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int CW_BITS = 3;
    localparam int MW      = 2;
    localparam int KW      = 4;
    localparam int MIN_K   = 3;

    typedef struct packed {
        logic [MW-1:0] same;
        logic [MW-1:0] flip;
    } bm_pair_t;

    function automatic logic [MW-1:0] ones3(input logic [CW_BITS-1:0] x);
        return {1'b0, x[0]} + {1'b0, x[1]} + {1'b0, x[2]};
    endfunction

endpackage

// File: rtl/bmu_cw_table.sv
module bmu_cw_table #(
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int CW    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [CW-1:0]         wdata,
    output logic [DEPTH*CW-1:0]   entries
);
    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign entries[g*CW +: CW] = mem[g];
    end
endmodule

// File: rtl/bmu_lane.sv
module bmu_lane
    import bmu_pkg::*;
(
    input  logic [CW_BITS-1:0] rx_bits,
    input  logic [CW_BITS-1:0] codeword,
    input  logic [CW_BITS-1:0] keep_mask,
    output bm_pair_t           pair
);
    always_comb begin
        pair.same = ones3((rx_bits ^ codeword) & keep_mask);
        pair.flip = ones3((rx_bits ^ ~codeword) & keep_mask);
    end
endmodule

// File: rtl/programmable_bmu.sv
module programmable_bmu
    import bmu_pkg::*;
#(
    parameter int MAX_K = 9
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [MAX_K-3:0]                   cfg_addr,
    input  logic [CW_BITS-1:0]                 cfg_data,
    input  logic                               rx_valid,
    input  logic [CW_BITS-1:0]                 rx_bits,
    input  logic [KW-1:0]                      k_len,
    input  logic                               rate_third,
    output logic                               out_valid,
    output logic [(1<<(MAX_K-2))-1:0]          lane_valid,
    output logic [(1<<(MAX_K-2))*MW-1:0]       bm_same,
    output logic [(1<<(MAX_K-2))*MW-1:0]       bm_flip
);
    localparam int AW = MAX_K - 2;
    localparam int NB = 1 << AW;

    logic [NB*CW_BITS-1:0] entries;
    logic [KW-1:0]         k_eff;
    logic [AW:0]           active_lim;
    logic [NB-1:0]         active;
    logic [CW_BITS-1:0]    keep_mask;
    bm_pair_t              pair_c [NB];

    bmu_cw_table #(.DEPTH(NB), .AW(AW), .CW(CW_BITS)) table_i (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .waddr   (cfg_addr),
        .wdata   (cfg_data),
        .entries (entries)
    );

    always_comb begin
        if (k_len < KW'(MIN_K))      k_eff = KW'(MIN_K);
        else if (k_len > KW'(MAX_K)) k_eff = KW'(MAX_K);
        else                         k_eff = k_len;
        active_lim = (AW+1)'(1) << (k_eff - KW'(2));
        keep_mask  = rate_third ? 3'b111 : 3'b011;
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam logic [AW:0] IDX = (AW+1)'(g);
        assign active[g] = (IDX < active_lim);
        bmu_lane lane_i (
            .rx_bits   (rx_bits),
            .codeword  (entries[g*CW_BITS +: CW_BITS]),
            .keep_mask (keep_mask),
            .pair      (pair_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            lane_valid <= '0;
            bm_same    <= '0;
            bm_flip    <= '0;
        end else begin
            out_valid <= rx_valid;
            for (int i = 0; i < NB; i++) begin
                if (rx_valid && active[i]) begin
                    lane_valid[i]          <= 1'b1;
                    bm_same[i*MW +: MW]    <= pair_c[i].same;
                    bm_flip[i*MW +: MW]    <= pair_c[i].flip;
                end else begin
                    lane_valid[i]          <= 1'b0;
                    bm_same[i*MW +: MW]    <= '0;
                    bm_flip[i*MW +: MW]    <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
    import bmu_pkg::*;
#(
    parameter int MAX_K = 9
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              rx_valid,
    input logic                              rate_third,
    input logic                              out_valid,
    input logic [(1<<(MAX_K-2))-1:0]         lane_valid,
    input logic [(1<<(MAX_K-2))*MW-1:0]      bm_same,
    input logic [(1<<(MAX_K-2))*MW-1:0]      bm_flip
);
    localparam int NB = 1 << (MAX_K - 2);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> out_valid); // R6
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !out_valid); // R6
    AST_MIN_LANES: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (lane_valid[0] && lane_valid[1])); // R9

    for (genvar g = 0; g < NB; g++) begin : g_chk
        AST_LANE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
            lane_valid[g] |-> out_valid); // R6
        AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !lane_valid[g] |-> (bm_same[g*MW +: MW] == '0 && bm_flip[g*MW +: MW] == '0)); // R7
        AST_PAIR_SUM: assert property (@(posedge clk) disable iff (rst)
            lane_valid[g] |-> (({1'b0, bm_same[g*MW +: MW]} + {1'b0, bm_flip[g*MW +: MW]})
                               == ($past(rate_third) ? 3'd3 : 3'd2))); // R4
        if (g > 0) begin : g_contig
            AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
                lane_valid[g] |-> lane_valid[g-1]); // R7
        end
    end
endmodule

bind programmable_bmu bmu_checker #(.MAX_K(MAX_K)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rate_third (rate_third),
    .out_valid  (out_valid),
    .lane_valid (lane_valid),
    .bm_same    (bm_same),
    .bm_flip    (bm_flip)
);

// File: tb/programmable_bmu_tb.sv
module programmable_bmu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_K = 9;
    localparam int AW = MAX_K - 2;
    localparam int NB = 1 << AW;

    typedef struct {
        logic [NB*2-1:0] same;
        logic [NB*2-1:0] flip;
        logic [NB-1:0]   lv;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [2:0] cfg_data = '0;
    logic rx_valid = 1'b0;
    logic [2:0] rx_bits = '0;
    logic [3:0] k_len = 4'd9;
    logic rate_third = 1'b1;
    logic out_valid;
    logic [NB-1:0] lane_valid;
    logic [NB*2-1:0] bm_same;
    logic [NB*2-1:0] bm_flip;

    int checks = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic prev_rx = 1'b0;
    logic [2:0] shadow [NB];
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    programmable_bmu #(.MAX_K(MAX_K)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .rx_valid(rx_valid), .rx_bits(rx_bits), .k_len(k_len), .rate_third(rate_third),
        .out_valid(out_valid), .lane_valid(lane_valid), .bm_same(bm_same), .bm_flip(bm_flip)
    );

    function automatic logic [1:0] pc3(input logic [2:0] x);
        int c = 0;
        for (int b = 0; b < 3; b++) c += int'(x[b]);
        return 2'(c);
    endfunction

    function automatic exp_t model(input logic [2:0] rx, input logic [3:0] k,
                                   input logic r3, input string tag);
        exp_t e;
        int keff;
        int nact;
        logic [2:0] m;
        keff = (k < 3) ? 3 : ((k > 9) ? 9 : int'(k));
        nact = 1 << (keff - 2);
        m = r3 ? 3'b111 : 3'b011;
        e.same = '0; e.flip = '0; e.lv = '0; e.tag = tag;
        for (int i = 0; i < NB; i++) begin
            if (i < nact) begin
                e.lv[i] = 1'b1;
                e.same[i*2 +: 2] = pc3((rx ^ shadow[i]) & m);
                e.flip[i*2 +: 2] = pc3((rx ^ ~shadow[i]) & m);
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NB*2-1:0] act, input logic [NB*2-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] rx, input logic [3:0] k, input logic r3, input string tag);
        @(posedge clk); #2;
        cfg_we = 1'b0;
        rx_valid = 1'b1; rx_bits = rx; k_len = k; rate_third = r3;
        q.push_back(model(rx, k, r3, tag));
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #2;
            rx_valid = 1'b0; cfg_we = 1'b0;
        end
    endtask

    task automatic cfg(input int addr, input logic [2:0] data);
        @(posedge clk); #2;
        rx_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = data;
        shadow[addr] = data;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && !done) begin
            check(out_valid == prev_rx, "R6", "out_valid latency", {{(NB*2-1){1'b0}}, out_valid},
                  {{(NB*2-1){1'b0}}, prev_rx});
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6", "unexpected output", '0, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(bm_same == e.same, e.tag, "same metrics", bm_same, e.same);
                    check(bm_flip == e.flip, e.tag, "flip metrics", bm_flip, e.flip);
                    check(lane_valid == e.lv, e.tag, "lane valid", {{NB{1'b0}}, lane_valid},
                          {{NB{1'b0}}, e.lv});
                end
            end else begin
                check(lane_valid == '0 && bm_same == '0 && bm_flip == '0, "R8", "idle outputs",
                      bm_same | bm_flip | {{NB{1'b0}}, lane_valid}, '0);
            end
            prev_rx = rx_valid;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) shadow[i] = 3'b000;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(out_valid == 1'b0 && lane_valid == '0, "R1", "reset flags",
              {{NB{1'b0}}, lane_valid}, '0);
        check(bm_same == '0 && bm_flip == '0, "R1", "reset metrics", bm_same | bm_flip, '0);
        mon_on = 1'b1;

        // R1: table cleared to zero codewords
        send(3'b000, 4'd9, 1'b1, "R1");
        send(3'b111, 4'd9, 1'b0, "R1");
        idle(2);

        // R2: program every entry with a distinct pattern
        for (int i = 0; i < NB; i++) cfg(i, 3'((i * 5 + 3) % 8));
        idle(1);

        // R3 / R4: full rate 1/3, all received patterns, back to back
        for (int v = 0; v < 8; v++) send(3'(v), 4'd9, 1'b1, v[0] ? "R3" : "R4");
        idle(2);

        // R5: rate 1/2, bit 2 toggled must not matter
        for (int v = 0; v < 8; v++) send(3'(v), 4'd9, 1'b0, "R5");
        idle(1);

        // R7: smaller constraint lengths, with gaps (R8)
        for (int k = 3; k <= 8; k++) begin
            send(3'b110, 4'(k), 1'(k % 2), "R7");
            idle(1);
        end

        // R9: out-of-range constraint lengths
        send(3'b101, 4'd0, 1'b1, "R9");
        send(3'b101, 4'd2, 1'b0, "R9");
        send(3'b101, 4'd10, 1'b1, "R9");
        send(3'b101, 4'd15, 1'b0, "R9");
        idle(2);

        // R2: overwrite entries and check they take effect
        cfg(5, 3'b010);
        cfg(127, 3'b101);
        cfg(0, 3'b111);
        idle(1);
        send(3'b011, 4'd9, 1'b1, "R2");
        send(3'b100, 4'd3, 1'b1, "R2");
        idle(4);

        check(q.size() == 0, "R6", "pending expected items", (NB*2)'(q.size()), '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule